// File: doc/BRIEF.md
# Three-Bank Interrupt Collector

This block gathers 24 single-cycle event pulses into three 8-bit banks and drives one active-high interrupt request. Each bank has three registers: a sticky status byte, a line mask that decides which latched bits may raise the request, and a status mask that decides which events may latch at all. A mask bit of 1 blocks its source; a bit of 0 lets it through. After reset every mask is all ones and every status bit is zero, so nothing latches and nothing signals until software opens the masks.

Software reaches the registers through a byte-wide port with an auto-incrementing pointer. A small two-state controller holds the transfer: in `ST_IDLE` strobes are ignored; the *open* transition (`bus_start`) loads the pointer from `bus_addr` and enters `ST_XFER`; in `ST_XFER` each strobe reads or writes the byte at the pointer and then increments it (wrapping at the top of the address space); a further `bus_start` *reopens* at a new address without leaving `ST_XFER`; the *close* transition (`bus_stop`) returns to `ST_IDLE`. Because the three status bytes sit at consecutive addresses, one three-strobe read starting at address 0 returns banks A, B and C. A byte write of any value to any status address clears all 24 status bits.

Top module: `irq_aggregator`

## Requirements
- R1: After reset all status bytes read 0x00, all six mask bytes read 0xFF and `irq_out` is 0.
- R2: An event pulse on source n sets status bit n only while status-mask bit n is 0; a set bit stays set until a clear write.
- R3: `irq_out` is registered: it is 1 in the cycle after any status bit whose line-mask bit is 0 is set, and 0 in the cycle after none is; line masking never stops a bit from latching.
- R4: A byte write of any data to address 0, 1 or 2 clears all 24 status bits.
- R5: An unmasked event arriving in the same cycle as a clear write is latched, so the status after that edge holds exactly that cycle's unmasked events.
- R6: Sources 12 and 23 are reserved: their status bits never latch and read as 0 (bank B reads bit 4 as 0, bank C reads bit 7 as 0).
- R7: Address map: status A/B/C at 0/1/2, line masks A/B/C at 3/4/5, status masks A/B/C at 6/7/8; bank A holds sources 0–7, B 8–15, C 16–23, lowest source in bit 0; mask bytes read back the last value written, so read-modify-write on one mask byte leaves the others unchanged.
- R8: `bus_start` loads the pointer; each strobe in `ST_XFER` accesses the pointer address and then increments it, wrapping from 15 to 0.
- R9: Addresses 9 to 15 read as 0x00 and ignore writes.
- R10: In `ST_IDLE` strobes have no effect; `bus_stop` returns the port to `ST_IDLE`.
- R11: `bus_rdata` is registered: it takes the addressed byte at the edge of a read strobe and holds it until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_evt | input | 24 | Event pulses, one per source |
| bus_start | input | 1 | Open (or reopen) a transfer at `bus_addr` |
| bus_addr | input | 4 | Start address of a transfer |
| bus_stop | input | 1 | Close the transfer |
| bus_stb | input | 1 | One byte access at the pointer |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by `bus_stb` |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_out | output | 1 | Registered interrupt request, active high |

## Verification
The properties assume the event inputs and port controls are driven to known values from the first clock edge and change only away from the rising edge; the bench drives every input from time zero and updates them on falling edges. They also assume `bus_start` and `bus_stb` are not raised together, since the open takes priority and the strobe is dropped; the bench's helper tasks always separate the open, the strobes and the close into different cycles. Events are held for exactly one cycle per pulse, including the pulse placed on the same edge as a clear write.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } port_state_e;

endpackage

// File: rtl/irq_bus_fsm.sv
module irq_bus_fsm
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic              stop,
    input  logic              stb,
    input  logic              wr,
    output logic              acc_rd,
    output logic              acc_wr,
    output logic [ADDR_W-1:0] acc_addr
);

    port_state_e       state_q, state_d;
    logic [ADDR_W-1:0] ptr_q;
    logic              acc;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_XFER;
            ST_XFER: begin
                if (start)     state_d = ST_XFER;
                else if (stop) state_d = ST_IDLE;
            end
        endcase
    end

    // state register together with the address pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start)    ptr_q <= addr;
            else if (acc) ptr_q <= ptr_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        acc      = 1'b0;
        acc_addr = ptr_q;
        unique case (state_q)
            ST_IDLE: acc = 1'b0;
            ST_XFER: acc = stb && !start;
        endcase
        acc_rd = acc && !wr;
        acc_wr = acc && wr;
    end

endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
    parameter int             W   = 8,
    parameter logic [W-1:0]   RSV = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         clr,
    input  logic         lm_we,
    input  logic         sm_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] status,
    output logic [W-1:0] lmask,
    output logic [W-1:0] smask
);

    logic [W-1:0] admit;
    logic [W-1:0] kept;

    assign admit = evt & ~smask & ~RSV;
    assign kept  = clr ? '0 : status;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
            lmask  <= '1;
            smask  <= '1;
        end else begin
            status <= kept | admit;
            if (lm_we) lmask <= wdata;
            if (sm_we) smask <= wdata;
        end
    end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
    parameter int N_BANK   = 3,
    parameter int BANK_W   = 8,
    parameter int ADDR_W   = 4,
    parameter logic [N_BANK*BANK_W-1:0] RSV_MASK = 24'h80_1000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_BANK*BANK_W-1:0] src_evt,
    input  logic                     bus_start,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_stop,
    input  logic                     bus_stb,
    input  logic                     bus_wr,
    input  logic [BANK_W-1:0]        bus_wdata,
    output logic [BANK_W-1:0]        bus_rdata,
    output logic                     irq_out
);

    localparam int N_SRC = N_BANK * BANK_W;
    localparam logic [ADDR_W-1:0] LM_BASE = ADDR_W'(N_BANK);
    localparam logic [ADDR_W-1:0] SM_BASE = ADDR_W'(2 * N_BANK);

    logic              acc_rd, acc_wr;
    logic [ADDR_W-1:0] acc_addr;
    logic              clr_hit;
    logic [N_SRC-1:0]  status_all, lmask_all, smask_all;
    logic [BANK_W-1:0] rd_val, rd_q;
    logic              irq_q;

    irq_bus_fsm #(.ADDR_W(ADDR_W)) u_port (
        .clk(clk), .rst_n(rst_n), .start(bus_start), .addr(bus_addr),
        .stop(bus_stop), .stb(bus_stb), .wr(bus_wr),
        .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_addr(acc_addr)
    );

    // any write below the line-mask block hits a status byte
    assign clr_hit = acc_wr && (acc_addr < LM_BASE);

    for (genvar g = 0; g < N_BANK; g++) begin : g_bank
        logic lm_we, sm_we;
        assign lm_we = acc_wr && (acc_addr == LM_BASE + ADDR_W'(g));
        assign sm_we = acc_wr && (acc_addr == SM_BASE + ADDR_W'(g));
        irq_bank #(
            .W(BANK_W),
            .RSV(RSV_MASK[g*BANK_W +: BANK_W])
        ) u_bank (
            .clk(clk), .rst_n(rst_n),
            .evt(src_evt[g*BANK_W +: BANK_W]),
            .clr(clr_hit), .lm_we(lm_we), .sm_we(sm_we), .wdata(bus_wdata),
            .status(status_all[g*BANK_W +: BANK_W]),
            .lmask(lmask_all[g*BANK_W +: BANK_W]),
            .smask(smask_all[g*BANK_W +: BANK_W])
        );
    end

    always_comb begin
        rd_val = '0;
        for (int b = 0; b < N_BANK; b++) begin
            if (acc_addr == ADDR_W'(b))           rd_val = status_all[b*BANK_W +: BANK_W];
            if (acc_addr == LM_BASE + ADDR_W'(b)) rd_val = lmask_all[b*BANK_W +: BANK_W];
            if (acc_addr == SM_BASE + ADDR_W'(b)) rd_val = smask_all[b*BANK_W +: BANK_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            irq_q <= 1'b0;
        end else begin
            if (acc_rd) rd_q <= rd_val;
            irq_q <= |(status_all & ~lmask_all);
        end
    end

    assign bus_rdata = rd_q;
    assign irq_out   = irq_q;

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
    parameter int N_SRC  = 24,
    parameter int BANK_W = 8,
    parameter int ADDR_W = 4,
    parameter int MAP_TOP = 9,
    parameter logic [N_SRC-1:0] RSV_MASK = 24'h80_1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  src_evt,
    input logic [N_SRC-1:0]  status_all,
    input logic [N_SRC-1:0]  lmask_all,
    input logic [N_SRC-1:0]  smask_all,
    input logic              clr_hit,
    input logic              acc_rd,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [BANK_W-1:0] bus_rdata,
    input logic              irq_out
);

    // R3
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status_all & ~lmask_all)) |=> irq_out);

    // R3
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(status_all & ~lmask_all)) |=> !irq_out);

    // R2
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_hit |=> ((status_all & $past(status_all)) == $past(status_all)));

    // R2
    masked_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_all & ~$past(status_all) & $past(smask_all)) == '0));

    // R4 R5
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> (status_all == $past(src_evt & ~smask_all & ~RSV_MASK)));

    // R6
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_all & RSV_MASK) == '0);

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && (acc_addr >= ADDR_W'(MAP_TOP))) |=> (bus_rdata == '0));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_rd |=> $stable(bus_rdata));

endmodule

bind irq_aggregator irq_aggregator_chk #(
    .N_SRC(N_BANK * BANK_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W),
    .MAP_TOP(3 * N_BANK), .RSV_MASK(RSV_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt),
    .status_all(status_all), .lmask_all(lmask_all), .smask_all(smask_all),
    .clr_hit(clr_hit), .acc_rd(acc_rd), .acc_addr(acc_addr),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
);

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] src_evt = '0;
    logic        bus_start = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_stop = 1'b0;
    logic        bus_stb = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq_out;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_aggregator uut (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt),
        .bus_start(bus_start), .bus_addr(bus_addr), .bus_stop(bus_stop),
        .bus_stb(bus_stb), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic open_at(input logic [3:0] a);
        @(negedge clk); bus_start = 1'b1; bus_addr = a;
        @(negedge clk); bus_start = 1'b0;
    endtask

    task automatic close_xfer();
        bus_stop = 1'b1;
        @(negedge clk); bus_stop = 1'b0;
    endtask

    task automatic put(input logic [7:0] d);
        bus_stb = 1'b1; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk); bus_stb = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic get(output logic [7:0] d);
        bus_stb = 1'b1; bus_wr = 1'b0;
        @(negedge clk); bus_stb = 1'b0;
        d = bus_rdata;
    endtask

    task automatic read_at(input logic [3:0] a, input string req, input logic [7:0] exp);
        logic [7:0] d;
        open_at(a); get(d); close_xfer();
        chk(req, d, exp);
    endtask

    task automatic pulse(input logic [23:0] e);
        @(negedge clk); src_evt = e;
        @(negedge clk); src_evt = '0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 irq after reset", irq_out, 0);
        open_at(4'd0);
        for (int i = 0; i < 9; i++) begin
            get(d);
            chk(i < 3 ? "R1 status reset" : "R1 mask reset", d, i < 3 ? 8'h00 : 8'hFF);
        end
        close_xfer();
    endtask

    task automatic t_masked_events();
        pulse(24'hFF_FFFF);
        read_at(4'd0, "R2 masked A", 8'h00);
        read_at(4'd2, "R2 masked C", 8'h00);
    endtask

    task automatic t_latch_reserved();
        logic [7:0] d;
        open_at(4'd6); put(8'h00); put(8'h00); put(8'h00); close_xfer();
        pulse(24'hFF_FFFF);
        repeat (3) @(negedge clk);
        open_at(4'd0);
        get(d); chk("R2 sticky A", d, 8'hFF);
        get(d); chk("R6 reserved bit 12", d, 8'hEF);
        get(d); chk("R6 reserved bit 23", d, 8'h7F);
        close_xfer();
        chk("R3 line masked no irq", irq_out, 0);
    endtask

    task automatic t_line_unmask();
        open_at(4'd4);
        put(8'hFE);
        chk("R3 irq registered latency", irq_out, 0);
        @(negedge clk);
        chk("R3 irq raised", irq_out, 1);
        close_xfer();
    endtask

    task automatic t_clear();
        open_at(4'd2);
        put(8'h5A);
        chk("R3 irq held one cycle after clear", irq_out, 1);
        @(negedge clk);
        chk("R4 irq drops after clear", irq_out, 0);
        close_xfer();
        read_at(4'd0, "R4 A cleared", 8'h00);
        read_at(4'd1, "R4 B cleared", 8'h00);
        read_at(4'd2, "R4 C cleared", 8'h00);
    endtask

    task automatic t_clear_vs_event();
        open_at(4'd1);
        src_evt = 24'h01_0008;
        put(8'hC3);
        src_evt = '0;
        close_xfer();
        read_at(4'd0, "R5 event kept through clear", 8'h08);
        read_at(4'd2, "R5 C event kept", 8'h01);
    endtask

    task automatic t_unmapped_wrap();
        logic [7:0] d;
        open_at(4'd8); put(8'h00); put(8'h33); close_xfer();
        read_at(4'd9, "R9 unmapped reads zero", 8'h00);
        read_at(4'd8, "R9 neighbour unharmed", 8'h00);
        open_at(4'd15);
        get(d); chk("R9 top address zero", d, 8'h00);
        get(d); chk("R8 pointer wraps to 0", d, 8'h08);
        close_xfer();
    endtask

    task automatic t_idle_and_rmw();
        logic [7:0] d;
        open_at(4'd5); close_xfer();
        put(8'h00);
        read_at(4'd5, "R10 idle strobe ignored", 8'hFF);
        open_at(4'd5); get(d); close_xfer();
        open_at(4'd5); put(d & ~8'h02); close_xfer();
        open_at(4'd3);
        get(d); chk("R7 line mask A untouched", d, 8'hFF);
        get(d); chk("R7 line mask B untouched", d, 8'hFE);
        get(d); chk("R7 RMW line mask C", d, 8'hFD);
        close_xfer();
        @(negedge clk);
        chk("R11 rdata held", bus_rdata, 8'hFD);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masked_events();
        t_latch_reserved();
        t_line_unmask();
        t_clear();
        t_clear_vs_event();
        t_unmapped_wrap();
        t_idle_and_rmw();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R10: actual hung expected finished");
        finish_run();
    end

endmodule